// File: doc/BRIEF.md
# I2C Register Bank Target

This block is an I2C target that owns a small bank of 8-bit registers. An external bus master reaches the bank over SCL and SDA, and local logic on the same chip can load it through a plain write port. SCL and SDA are sampled by the system clock through a short synchronizer. START, repeated START and STOP are detected from the synchronized levels. The block never drives the bus lines directly. It only raises enable outputs for external pull-down and pull-up drivers.

A write transaction carries the device address byte, then a byte that sets the register pointer, then any number of data bytes. Each data byte is stored at the pointer and the pointer then advances. A read transaction streams registers from the current pointer onward, one per byte, until the master answers with a not-acknowledge. The pointer keeps its value across STOP. A combined read (write address, pointer byte, repeated START, read address) therefore starts wherever the master chose, and a later standalone read carries on after the last register sent. The pointer wraps modulo the register count, which must be a power of two and at least four. The lowest four registers are always visible on parallel outputs.

The local port writes on every clock that its strobe is high. If an I2C write lands on the same clock, the I2C write takes precedence.

Top module: `i2c_regbank_target`

## Requirements
- R1: After synchronous reset, every register reads 0x00, the pointer is 0 and all three bus enables are low.
- R2: The received address byte is compared with `dev_addr_i` on bits 7..1 only. Bit 0 of the received byte selects the direction: 0 is a write and 1 is a read. On a match, the target pulls SDA low for the whole ninth clock (acknowledge).
- R3: When the address does not match, the target gives no acknowledge and ignores every byte until the next START. No register changes.
- R4: In a write, the first byte after the address loads the pointer with its low log2(NUM_REGS) bits and is acknowledged.
- R5: Each further write byte is stored at the pointer and acknowledged, then the pointer increments modulo NUM_REGS.
- R6: In a read, each byte sent MSB first is the register at the pointer, and the pointer increments after every byte sent. A master acknowledge (SDA low on the ninth clock) requests the next byte.
- R7: After a master not-acknowledge (SDA high on the ninth clock), the target drives nothing on SDA until the next START.
- R8: The pointer keeps its value through STOP. A standalone read continues from it.
- R9: While `loc_we_i` is high and no I2C write occurs on that clock, `loc_data_i` is written to register `loc_idx_i` on the next clock edge.
- R10: `reg0_o` through `reg3_o` continuously show registers 0 to 3.
- R11: `sda_pd_o` and `sda_pu_o` are never high together, and `scl_pd_o` is never asserted.
- R12: The SDA enables only become asserted while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_pd_o | output | 1 | SCL pull-down enable (held low) |
| sda_pd_o | output | 1 | SDA pull-down enable |
| sda_pu_o | output | 1 | SDA pull-up enable while sending a 1 |
| dev_addr_i | input | 8 | Device address byte; bit 0 ignored in the match |
| loc_idx_i | input | log2(NUM_REGS) | Local write register index |
| loc_we_i | input | 1 | Local write strobe |
| loc_data_i | input | 8 | Local write data |
| reg0_o | output | 8 | Register 0 contents |
| reg1_o | output | 8 | Register 1 contents |
| reg2_o | output | 8 | Register 2 contents |
| reg3_o | output | 8 | Register 3 contents |

## Verification
The bench builds the block with NUM_REGS set to 4 and the default two-stage synchronizer. With four registers, every register in the bank is visible on the parallel outputs, so the reference model can compare the whole bank on every clock. Pointer wrap also becomes reachable within a three-byte burst and a four-byte read. A pointer byte of 0x06 shows that only the low pointer bits are kept. The SCL period is 80 system clocks, which leaves enough clocks in each SCL phase for the synchronizer delay before the target changes SDA.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RACK,
        ST_TX,
        ST_TACK,
        ST_SKIP
    } tgt_state_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_PTR,
        K_DATA
    } byte_kind_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [7:0] rx, input logic [7:0] dev);
        return ((rx ^ dev) & 8'hFE) == 8'h00;
    endfunction

    function automatic byte_kind_e kind_after(input byte_kind_e k);
        return (k == K_ADDR) ? K_PTR : K_DATA;
    endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
`timescale 1ns/1ps
module i2c_tgt_sync
    import i2c_tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] cur;
    logic [LINES-1:0] prv;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] hist_q;
        always_ff @(posedge clk) begin
            if (rst) hist_q <= '1;
            else     hist_q <= {hist_q[STAGES-1:0], raw[g]};
        end
        assign cur[g] = hist_q[STAGES-1];
        assign prv[g] = hist_q[STAGES];
    end

    // index 1 = SCL, index 0 = SDA
    always_comb begin
        evt_o.scl_rise = cur[1] & ~prv[1];
        evt_o.scl_fall = ~cur[1] & prv[1];
        evt_o.start    = cur[1] & prv[1] & ~cur[0] & prv[0];
        evt_o.stop     = cur[1] & prv[1] & cur[0] & ~prv[0];
        evt_o.sda      = cur[0];
    end
endmodule

// File: rtl/i2c_tgt_bank.sv
`timescale 1ns/1ps
module i2c_tgt_bank #(
    parameter int NUM_REGS = 8,
    parameter int IDX_W    = $clog2(NUM_REGS),
    parameter int TAPS     = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_we,
    input  logic [IDX_W-1:0]     bus_idx,
    input  logic [7:0]           bus_data,
    input  logic                 loc_we,
    input  logic [IDX_W-1:0]     loc_idx,
    input  logic [7:0]           loc_data,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [7:0]           rd_data,
    output logic [TAPS-1:0][7:0] tap_o
);
    logic [NUM_REGS-1:0][7:0] mem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (bus_we && bus_idx == IDX_W'(i))
                    mem_q[i] <= bus_data;
                else if (loc_we && loc_idx == IDX_W'(i))
                    mem_q[i] <= loc_data;
            end
        end
    end

    assign rd_data = mem_q[rd_idx];

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        assign tap_o[t] = mem_q[t];
    end
endmodule

// File: rtl/i2c_tgt_engine.sv
`timescale 1ns/1ps
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_evt_t         evt,
    input  logic [7:0]       dev_addr,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] ptr_o,
    output logic             we_o,
    output logic [7:0]       wdata_o,
    output logic             sda_pd,
    output logic             sda_pu
);
    tgt_state_e       state_q;
    byte_kind_e       kind_q;
    logic [7:0]       shreg_q;
    logic [3:0]       bitcnt_q;
    logic             done_q;
    logic             rdmode_q;
    logic             mack_q;
    logic [IDX_W-1:0] ptr_q;

    logic byte_end;
    assign byte_end = (state_q == ST_RX) && evt.scl_fall && done_q;

    assign we_o    = byte_end && (kind_q == K_DATA);
    assign wdata_o = shreg_q;
    assign ptr_o   = ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            kind_q   <= K_ADDR;
            shreg_q  <= '0;
            bitcnt_q <= '0;
            done_q   <= 1'b0;
            rdmode_q <= 1'b0;
            mack_q   <= 1'b0;
            ptr_q    <= '0;
        end else if (evt.start) begin
            state_q  <= ST_RX;
            kind_q   <= K_ADDR;
            bitcnt_q <= '0;
            done_q   <= 1'b0;
            rdmode_q <= 1'b0;
        end else if (evt.stop) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_RX: begin
                    if (evt.scl_rise && !done_q) begin
                        shreg_q  <= {shreg_q[6:0], evt.sda};
                        bitcnt_q <= bitcnt_q + 4'd1;
                        if (bitcnt_q == 4'd7) done_q <= 1'b1;
                    end else if (byte_end) begin
                        done_q <= 1'b0;
                        unique case (kind_q)
                            K_ADDR: begin
                                if (addr_hit(shreg_q, dev_addr)) begin
                                    state_q  <= ST_RACK;
                                    rdmode_q <= shreg_q[0];
                                end else begin
                                    state_q <= ST_SKIP;
                                end
                            end
                            K_PTR: begin
                                ptr_q   <= shreg_q[IDX_W-1:0];
                                state_q <= ST_RACK;
                            end
                            default: begin
                                ptr_q   <= ptr_q + IDX_W'(1);
                                state_q <= ST_RACK;
                            end
                        endcase
                    end
                end
                ST_RACK: begin
                    if (evt.scl_fall) begin
                        bitcnt_q <= '0;
                        if (rdmode_q && kind_q == K_ADDR) begin
                            state_q <= ST_TX;
                            shreg_q <= rd_data;
                        end else begin
                            state_q <= ST_RX;
                            kind_q  <= kind_after(kind_q);
                        end
                    end
                end
                ST_TX: begin
                    if (evt.scl_rise) begin
                        bitcnt_q <= bitcnt_q + 4'd1;
                    end else if (evt.scl_fall) begin
                        if (bitcnt_q == 4'd8) begin
                            state_q <= ST_TACK;
                            ptr_q   <= ptr_q + IDX_W'(1);
                        end else begin
                            shreg_q <= {shreg_q[6:0], 1'b0};
                        end
                    end
                end
                ST_TACK: begin
                    if (evt.scl_rise) begin
                        mack_q <= ~evt.sda;
                    end else if (evt.scl_fall) begin
                        if (mack_q) begin
                            state_q  <= ST_TX;
                            shreg_q  <= rd_data;
                            bitcnt_q <= '0;
                        end else begin
                            state_q <= ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        sda_pd = (state_q == ST_RACK) || (state_q == ST_TX && !shreg_q[7]);
        sda_pu = (state_q == ST_TX) && shreg_q[7];
    end
endmodule

// File: rtl/i2c_regbank_target.sv
`timescale 1ns/1ps
module i2c_regbank_target
    import i2c_tgt_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        scl_i,
    input  logic                        sda_i,
    output logic                        scl_pd_o,
    output logic                        sda_pd_o,
    output logic                        sda_pu_o,
    input  logic [7:0]                  dev_addr_i,
    input  logic [$clog2(NUM_REGS)-1:0] loc_idx_i,
    input  logic                        loc_we_i,
    input  logic [7:0]                  loc_data_i,
    output logic [7:0]                  reg0_o,
    output logic [7:0]                  reg1_o,
    output logic [7:0]                  reg2_o,
    output logic [7:0]                  reg3_o
);
    localparam int IDX_W = $clog2(NUM_REGS);
    localparam int TAPS  = 4;

    bus_evt_t             evt;
    logic [IDX_W-1:0]     ptr;
    logic                 bus_we;
    logic [7:0]           bus_wdata;
    logic [7:0]           rd_data;
    logic [TAPS-1:0][7:0] taps;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt)
    );

    i2c_tgt_engine #(.IDX_W(IDX_W)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .dev_addr (dev_addr_i),
        .rd_data  (rd_data),
        .ptr_o    (ptr),
        .we_o     (bus_we),
        .wdata_o  (bus_wdata),
        .sda_pd   (sda_pd_o),
        .sda_pu   (sda_pu_o)
    );

    i2c_tgt_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .TAPS(TAPS)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .bus_we   (bus_we),
        .bus_idx  (ptr),
        .bus_data (bus_wdata),
        .loc_we   (loc_we_i),
        .loc_idx  (loc_idx_i),
        .loc_data (loc_data_i),
        .rd_idx   (ptr),
        .rd_data  (rd_data),
        .tap_o    (taps)
    );

    assign scl_pd_o = 1'b0;
    assign reg0_o   = taps[0];
    assign reg1_o   = taps[1];
    assign reg2_o   = taps[2];
    assign reg3_o   = taps[3];
endmodule

// File: rtl/i2c_regbank_target_chk.sv
`timescale 1ns/1ps
module i2c_regbank_target_chk #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             scl_i,
    input logic             sda_pd_o,
    input logic             sda_pu_o,
    input logic             loc_we_i,
    input logic [IDX_W-1:0] loc_idx_i,
    input logic [7:0]       loc_data_i,
    input logic             bus_we,
    input logic [7:0]       reg0_o,
    input logic [7:0]       reg1_o,
    input logic [7:0]       reg2_o,
    input logic [7:0]       reg3_o
);
    AST_PU_PD_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(sda_pd_o && sda_pu_o)); // R11

    AST_PD_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pd_o) |-> !scl_i); // R12

    AST_PU_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pu_o) |-> !scl_i); // R12

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (reg0_o == 8'h00 && reg3_o == 8'h00 && !sda_pd_o && !sda_pu_o)); // R1

    AST_LOCAL_WRITE: assert property (@(posedge clk) disable iff (rst)
        (loc_we_i && !bus_we && loc_idx_i == '0) |=> (reg0_o == $past(loc_data_i))); // R9

    AST_LOCAL_WRITE_R1: assert property (@(posedge clk) disable iff (rst)
        (loc_we_i && !bus_we && loc_idx_i == IDX_W'(1)) |=> (reg1_o == $past(loc_data_i))); // R9
endmodule

bind i2c_regbank_target i2c_regbank_target_chk #(.IDX_W($clog2(NUM_REGS))) u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_pd_o   (sda_pd_o),
    .sda_pu_o   (sda_pu_o),
    .loc_we_i   (loc_we_i),
    .loc_idx_i  (loc_idx_i),
    .loc_data_i (loc_data_i),
    .bus_we     (bus_we),
    .reg0_o     (reg0_o),
    .reg1_o     (reg1_o),
    .reg2_o     (reg2_o),
    .reg3_o     (reg3_o)
);

// File: tb/i2c_regbank_target_bench.sv
`timescale 1ns/1ps
module i2c_regbank_target_bench;
    localparam int NREG = 4;
    localparam int IW   = 2;
    localparam int Q    = 20;
    localparam int WD   = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic [7:0] dev_addr = 8'h74;
    logic [IW-1:0] loc_idx = '0;
    logic loc_we = 1'b0;
    logic [7:0] loc_data = '0;
    logic scl_pd, sda_pd, sda_pu;
    logic [7:0] r0, r1, r2, r3;
    logic sda_line;

    assign sda_line = m_sda & ~sda_pd;

    always #10 clk = ~clk;

    i2c_regbank_target #(.NUM_REGS(NREG)) u_i2c_regbank_target (
        .clk(clk), .rst(rst), .scl_i(m_scl & ~scl_pd), .sda_i(sda_line),
        .scl_pd_o(scl_pd), .sda_pd_o(sda_pd), .sda_pu_o(sda_pu),
        .dev_addr_i(dev_addr), .loc_idx_i(loc_idx), .loc_we_i(loc_we),
        .loc_data_i(loc_data), .reg0_o(r0), .reg1_o(r1), .reg2_o(r2), .reg3_o(r3)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;
    bit drv_seen = 1'b0;
    logic [7:0] mdl [NREG];
    int mptr = 0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the reference model
    always @(negedge clk) begin
        if (!rst) begin
            chk("R11 enables exclusive", int'(sda_pd & sda_pu), 0);
            chk("R11 scl never driven", int'(scl_pd), 0);
            if (cmp_on) begin
                chk("R10 reg0 tracks model", r0, mdl[0]);
                chk("R10 reg1 tracks model", r1, mdl[1]);
                chk("R10 reg2 tracks model", r2, mdl[2]);
                chk("R10 reg3 tracks model", r3, mdl[3]);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WD);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wq(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic tx_bit(input logic b);
        m_sda = b;    wq();
        m_scl = 1'b1; wq(2);
        m_scl = 1'b0; wq();
    endtask

    task automatic rx_bit(output logic b);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        b = sda_line;
        drv_seen = sda_pd | sda_pu;
        wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) tx_bit(v[i]);
        rx_bit(a);
        acked = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic nack);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            rx_bit(b);
            v[i] = b;
        end
        tx_bit(nack);
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic wr_txn(input logic [7:0] dv, input logic [7:0] p, input logic [7:0] d [$]);
        logic ak;
        cmp_on = 1'b0;
        bus_start();
        send_byte(dv, ak);  chk("R2 write address acked", ak, 1);
        send_byte(p, ak);   chk("R4 pointer byte acked", ak, 1);
        mptr = p % NREG;
        foreach (d[i]) begin
            send_byte(d[i], ak);
            chk("R5 data byte acked", ak, 1);
            mdl[mptr] = d[i];
            mptr = (mptr + 1) % NREG;
        end
        bus_stop();
        settle();
        cmp_on = 1'b1;
    endtask

    task automatic rd_bytes(input int n);
        logic [7:0] v;
        for (int i = 0; i < n; i++) begin
            recv_byte(v, (i == n - 1));
            chk("R6 read byte from pointer", v, mdl[mptr]);
            mptr = (mptr + 1) % NREG;
        end
    endtask

    task automatic loc_write(input int idx, input logic [7:0] v);
        cmp_on = 1'b0;
        @(negedge clk);
        loc_idx = IW'(idx); loc_data = v; loc_we = 1'b1;
        @(negedge clk);
        loc_we = 1'b0;
        mdl[idx] = v;
        @(negedge clk);
        cmp_on = 1'b1;
    endtask

    initial begin
        logic ak;
        logic b;
        for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 reg0 cleared", r0, 0);
        chk("R1 reg3 cleared", r3, 0);
        chk("R1 sda enables low", int'(sda_pd | sda_pu), 0);
        cmp_on = 1'b1;
        wq(2);

        // R9: local port loads
        loc_write(0, 8'hDE);
        chk("R9 local write reg0", r0, 8'hDE);
        loc_write(1, 8'hAD);
        loc_write(2, 8'hBE);
        loc_write(3, 8'hEF);
        chk("R9 local write reg3", r3, 8'hEF);

        // R2 R4 R5: single write at pointer 1
        wr_txn(8'h74, 8'h01, '{8'h33});
        chk("R5 reg1 written", r1, 8'h33);

        // R6: combined read from pointer 0, four bytes then NACK
        cmp_on = 1'b0;
        bus_start();
        send_byte(8'h74, ak); chk("R2 write address acked", ak, 1);
        send_byte(8'h00, ak); chk("R4 pointer zero acked", ak, 1);
        mptr = 0;
        bus_start();
        send_byte(8'h75, ak); chk("R2 read address acked", ak, 1);
        rd_bytes(4);
        // R7: after NACK the target stays off the line
        rx_bit(b);
        chk("R7 line released after nack", b, 1);
        chk("R7 no drive after nack", int'(drv_seen), 0);
        bus_stop();
        settle();
        cmp_on = 1'b1;

        // R8: standalone reads continue from the kept pointer (wrapped to 0)
        bus_start();
        send_byte(8'h75, ak); chk("R8 standalone read acked", ak, 1);
        chk("R8 pointer kept after stop", mptr, 0);
        rd_bytes(1);
        bus_stop();
        wq(4);
        bus_start();
        send_byte(8'h75, ak); chk("R8 second standalone acked", ak, 1);
        rd_bytes(2);
        bus_stop();
        settle();

        // R4 R5: pointer byte 0x06 keeps low bits (2); burst wraps 3 -> 0
        wr_txn(8'h74, 8'h06, '{8'hFA, 8'hCE, 8'h69});
        chk("R5 reg2 burst", r2, 8'hFA);
        chk("R5 reg3 burst", r3, 8'hCE);
        chk("R5 wrap into reg0", r0, 8'h69);

        // R3: mismatched addresses are not acked and data is ignored
        cmp_on = 1'b0;
        bus_start();
        send_byte(8'hA0, ak); chk("R3 foreign address not acked", ak, 0);
        send_byte(8'h01, ak); chk("R3 pointer byte ignored", ak, 0);
        send_byte(8'h55, ak); chk("R3 data byte ignored", ak, 0);
        bus_stop();
        settle();
        cmp_on = 1'b1;
        chk("R3 reg1 untouched", r1, 8'h33);
        cmp_on = 1'b0;
        bus_start();
        send_byte(8'h76, ak); chk("R3 near-miss address not acked", ak, 0);
        send_byte(8'h00, ak);
        send_byte(8'h11, ak); chk("R3 stray byte not acked", ak, 0);
        bus_stop();
        settle();
        cmp_on = 1'b1;
        chk("R3 reg0 untouched", r0, 8'h69);

        // R6: read after a write-only pointer set at 3 wraps to 0
        cmp_on = 1'b0;
        bus_start();
        send_byte(8'h74, ak);
        send_byte(8'h03, ak); chk("R4 pointer three acked", ak, 1);
        mptr = 3;
        bus_start();
        send_byte(8'h75, ak);
        rd_bytes(2);
        bus_stop();
        settle();
        cmp_on = 1'b1;
        wq(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule